// File: doc/BRIEF.md
# Delta-Sigma Conversion Sequencer

This block is the digital control core of a single-channel delta-sigma converter. It holds the user settings: a resolution code that also fixes the output data rate, a two-bit gain code, and a mode bit that picks repeating or single conversions. From these settings it runs the modulator. It enables the modulator at the start of each conversion and catches the modulator's done pulse. It raises a result-ready flag, and it paces the next conversion from a clock-enable divider whose length follows the resolution.

A conversion never starts straight after a power-on reset, a general-call reset or a wake-up command. A settling wait of `SETTLE_CYC` clock cycles comes first. In single-conversion mode the block drops into standby once the conversion period ends, and it stays there until a start command arrives. A general-call reset strobe has the same effect as power-on reset. Configuration writes are accepted at any time, but they change the outputs only when the next conversion starts.

Top module: `adc_conv_seq`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge), `res_code` = 00, `gain_code` = 00, the mode is continuous, and `result_rdy`, `mod_en` and `standby` are all 0.
- R2: Resolution code encoding: 00 = 12 bits, 01 = 14 bits, 10 = 16 bits, 11 = 18 bits. Consecutive conversion starts are `PRESC_DIV*BASE_TICKS*4^code` cycles apart. This is 16, 64, 256 and 1024 cycles with `PRESC_DIV`=4 and `BASE_TICKS`=4.
- R3: In continuous mode (mode bit 0), conversions restart every period without any command. `mod_en` is high from the start of a conversion until the cycle after `mod_done` is sampled.
- R4: In one-shot mode (mode bit 1), exactly one conversion runs. At the end of its period `standby` goes to 1 and `mod_en` stays 0. `standby` falls only on `start_req` or a general-call reset.
- R5: `mod_en` first rises on the `SETTLE_CYC`-th rising edge after `rst_n` is released. It rises on the (`SETTLE_CYC`+1)-th edge after the edge that samples a `start_req` in standby.
- R6: A `gcall_rst` pulse acts as power-on reset. On the next edge the active and pending settings return to their defaults, and `result_rdy`, `mod_en` and `standby` clear. `mod_en` then rises `SETTLE_CYC`+1 edges after the sampling edge, and the block runs in continuous mode at code 00.
- R7: A configuration write (`cfg_we` with `cfg_res`, `cfg_gain`, `cfg_oneshot`) made during a conversion leaves `res_code` and `gain_code` unchanged until the next conversion starts. From that start they show the written values.
- R8: `result_rdy` is set when `mod_done` is sampled while `mod_en` is high, and is cleared by `result_rd`. If both occur in the same cycle, the set wins.
- R9: `mod_done` while `mod_en` is low has no effect, and `start_req` outside standby has no effect on the conversion timing.
- R10: The gain code is two bits, with 00 = x1, 01 = x2, 10 = x4 and 11 = x8. It is delivered unchanged on `gain_code` for the conversion it was loaded into.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| gcall_rst | input | 1 | General-call reset strobe, one cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_res | input | 2 | Written resolution code |
| cfg_gain | input | 2 | Written gain code |
| cfg_oneshot | input | 1 | Written mode: 1 = one-shot, 0 = continuous |
| start_req | input | 1 | Start command, acted on only in standby |
| mod_done | input | 1 | Modulator conversion-done pulse |
| result_rd | input | 1 | Result read strobe, clears the ready flag |
| mod_en | output | 1 | Modulator enable for the running conversion |
| res_code | output | 2 | Resolution code of the current conversion |
| gain_code | output | 2 | Gain code of the current conversion |
| result_rdy | output | 1 | A completed result is waiting to be read |
| standby | output | 1 | Block is in low-power standby |

## Verification
The hardest state to reach is the wake-up path. It needs a one-shot setting loaded into a running conversion, the period to expire into standby, and then a start command to pass through the settling wait again. The bench gets there by writing the one-shot mode mid-conversion and waiting out the period. It also injects a stray done pulse while in standby and then times the restart edge by edge. A second hard case is a general-call reset that arrives after a non-default configuration has become active. The bench first starts a conversion from standby with new settings, and only then issues the reset.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes: two-bit resolution and gain codes, one mode bit.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        RES_12 = 2'b00,
        RES_14 = 2'b01,
        RES_16 = 2'b10,
        RES_18 = 2'b11
    } res_e;

    typedef struct packed {
        res_e       res;
        logic [1:0] gain;
        logic       oneshot;
    } seq_cfg_t;

    localparam seq_cfg_t CFG_POWERUP = '{res: RES_12, gain: 2'b00, oneshot: 1'b0};

    typedef enum logic [1:0] {
        ST_SETTLE = 2'b00,
        ST_CONV   = 2'b01,
        ST_WAIT   = 2'b10,
        ST_SLEEP  = 2'b11
    } seq_state_e;

endpackage

// File: rtl/adc_seq_cfg.sv
// Module: configuration store.
// Keeps a pending copy written at any time and an active copy that is
// loaded from the pending copy only when a conversion starts.
// Assumes: soft_rst is a one-cycle strobe; load and write in the same
// cycle load the old pending value (the write applies one start later).
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst,
    input  logic     wr_en,
    input  seq_cfg_t wr_cfg,
    input  logic     load,
    output seq_cfg_t act_cfg
);

    seq_cfg_t pend_q;
    seq_cfg_t act_q;

    // Pending settings: take every write, fall back to defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pend_q <= CFG_POWERUP;
        end else if (wr_en) begin
            pend_q <= wr_cfg;
        end
    end

    // Active settings: copied from pending at each conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            act_q <= CFG_POWERUP;
        end else if (load) begin
            act_q <= pend_q;
        end
    end

    assign act_cfg = act_q;

endmodule

// File: rtl/adc_seq_rate.sv
// Module: conversion period timer.
// A prescaler makes a clock enable; a tick counter runs to a terminal
// count of BASE_TICKS * 4^res. period_end is high from the last cycle of
// the period until the next go.
// Assumes: res is stable while run is high; go restarts the period.
module adc_seq_rate
    import adc_seq_pkg::*;
#(
    parameter int PRESC_DIV  = 4,
    parameter int BASE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic go,
    input  logic run,
    input  res_e res,
    output logic period_end
);

    localparam int TERM_MAX = BASE_TICKS * 64;
    localparam int TK_W     = $clog2(TERM_MAX + 1);

    logic            tick;
    logic [TK_W-1:0] tk_q;
    logic [TK_W-1:0] term_m1;
    logic            up_q;
    logic            last_now;

    generate
        if (PRESC_DIV > 1) begin : g_presc
            localparam int PW = $clog2(PRESC_DIV);
            logic [PW-1:0] pre_q;

            // Prescaler: free count inside a period, wraps at PRESC_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst || go) begin
                    pre_q <= '0;
                end else if (run) begin
                    pre_q <= (pre_q == PW'(PRESC_DIV - 1)) ? '0 : pre_q + 1'b1;
                end
            end

            assign tick = run && (pre_q == PW'(PRESC_DIV - 1));
        end else begin : g_direct
            assign tick = run;
        end
    endgenerate

    // Terminal count minus one, picked by the resolution code.
    always_comb begin
        term_m1 = TK_W'((BASE_TICKS << (2 * int'(res))) - 1);
    end

    assign last_now   = tick && (tk_q == term_m1);
    assign period_end = up_q || last_now;

    // Tick counter: counts clock enables up to the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || go) begin
            tk_q <= '0;
        end else if (tick && !last_now) begin
            tk_q <= tk_q + 1'b1;
        end
    end

    // Sticky end flag: keeps period_end high once the period is over.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || go) begin
            up_q <= 1'b0;
        end else if (run && last_now) begin
            up_q <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: sequencing state machine.
// Runs settle -> convert -> wait-for-period -> (next convert | sleep).
// Holds the settling counter and the result-ready flag.
// Assumes: oneshot is the mode of the conversion in progress;
// SETTLE_CYC >= 1.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start_req,
    input  logic mod_done,
    input  logic result_rd,
    input  logic period_end,
    input  logic oneshot,
    output logic go,
    output logic run,
    output logic mod_en,
    output logic standby,
    output logic result_rdy
);

    localparam int STL_W = $clog2(SETTLE_CYC + 1);

    seq_state_e       st_q;
    seq_state_e       st_nxt;
    logic [STL_W-1:0] stl_q;
    logic             rdy_q;
    logic             settle_done;

    assign settle_done = (stl_q == STL_W'(SETTLE_CYC - 1));

    // Next state and conversion-start decision.
    always_comb begin
        st_nxt = st_q;
        go     = 1'b0;
        unique case (st_q)
            ST_SETTLE: begin
                if (settle_done) begin
                    st_nxt = ST_CONV;
                    go     = 1'b1;
                end
            end
            ST_CONV: begin
                if (mod_done) begin
                    if (!period_end) begin
                        st_nxt = ST_WAIT;
                    end else if (oneshot) begin
                        st_nxt = ST_SLEEP;
                    end else begin
                        st_nxt = ST_CONV;
                        go     = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (period_end) begin
                    if (oneshot) begin
                        st_nxt = ST_SLEEP;
                    end else begin
                        st_nxt = ST_CONV;
                        go     = 1'b1;
                    end
                end
            end
            ST_SLEEP: begin
                if (start_req) begin
                    st_nxt = ST_SETTLE;
                end
            end
            default: st_nxt = ST_SETTLE;
        endcase
        if (soft_rst) begin
            st_nxt = ST_SETTLE;
            go     = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_SETTLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Settling counter: runs only while in the settle state.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || st_q != ST_SETTLE) begin
            stl_q <= '0;
        end else if (!settle_done) begin
            stl_q <= stl_q + 1'b1;
        end
    end

    // Ready flag: a done during a conversion sets it; a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rdy_q <= 1'b0;
        end else if (mod_done && st_q == ST_CONV) begin
            rdy_q <= 1'b1;
        end else if (result_rd) begin
            rdy_q <= 1'b0;
        end
    end

    assign run        = (st_q == ST_CONV) || (st_q == ST_WAIT);
    assign mod_en     = (st_q == ST_CONV);
    assign standby    = (st_q == ST_SLEEP);
    assign result_rdy = rdy_q;

endmodule

// File: rtl/adc_conv_seq.sv
// Module: top of the conversion sequencer.
// Ties the configuration store, the period timer and the state machine.
// Assumes: all inputs are synchronous to clk; gcall_rst is a strobe.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 30000,
    parameter int PRESC_DIV  = 26042,
    parameter int BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gcall_rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_res,
    input  logic [1:0] cfg_gain,
    input  logic       cfg_oneshot,
    input  logic       start_req,
    input  logic       mod_done,
    input  logic       result_rd,
    output logic       mod_en,
    output logic [1:0] res_code,
    output logic [1:0] gain_code,
    output logic       result_rdy,
    output logic       standby
);

    seq_cfg_t wr_cfg;
    seq_cfg_t act_cfg;
    logic     go;
    logic     run;
    logic     period_end;

    // Pack the write port into the configuration record.
    always_comb begin
        wr_cfg.res     = res_e'(cfg_res);
        wr_cfg.gain    = cfg_gain;
        wr_cfg.oneshot = cfg_oneshot;
    end

    adc_seq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (gcall_rst),
        .wr_en    (cfg_we),
        .wr_cfg   (wr_cfg),
        .load     (go),
        .act_cfg  (act_cfg)
    );

    adc_seq_rate #(
        .PRESC_DIV  (PRESC_DIV),
        .BASE_TICKS (BASE_TICKS)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (gcall_rst),
        .go         (go),
        .run        (run),
        .res        (act_cfg.res),
        .period_end (period_end)
    );

    adc_seq_ctrl #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (gcall_rst),
        .start_req  (start_req),
        .mod_done   (mod_done),
        .result_rd  (result_rd),
        .period_end (period_end),
        .oneshot    (act_cfg.oneshot),
        .go         (go),
        .run        (run),
        .mod_en     (mod_en),
        .standby    (standby),
        .result_rdy (result_rdy)
    );

    assign res_code  = act_cfg.res;
    assign gain_code = act_cfg.gain;

endmodule

// File: rtl/adc_conv_seq_chk.sv
// Module: port-level property checker bound to the sequencer top.
module adc_conv_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gcall_rst,
    input logic       start_req,
    input logic       mod_done,
    input logic       result_rd,
    input logic       mod_en,
    input logic [1:0] res_code,
    input logic [1:0] gain_code,
    input logic       result_rdy,
    input logic       standby
);

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(res_code) && !$past(gcall_rst)) |-> $rose(mod_en));

    // R10
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gain_code) && !$past(gcall_rst)) |-> $rose(mod_en));

    // R8
    rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_rdy) |-> $past(mod_done && mod_en));

    // R8
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(result_rd && !(mod_done && mod_en)) |-> !result_rdy);

    // R4
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> ($past(start_req) || $past(gcall_rst)));

    // R3
    conv_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mod_en) && !$past(gcall_rst)) |-> $past(mod_done));

    // R6
    gcall_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gcall_rst) |-> (res_code == 2'b00 && gain_code == 2'b00 &&
                              !result_rdy && !mod_en && !standby));

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gcall_rst  (gcall_rst),
    .start_req  (start_req),
    .mod_done   (mod_done),
    .result_rd  (result_rd),
    .mod_en     (mod_en),
    .res_code   (res_code),
    .gain_code  (gain_code),
    .result_rdy (result_rdy),
    .standby    (standby)
);

// File: tb/adc_conv_seq_test.sv
// Directed bench for the conversion sequencer.
module adc_conv_seq_test;

    localparam int SETTLE = 20;
    localparam int PRE    = 4;
    localparam int BASE   = 4;
    localparam int P0     = PRE * BASE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gcall_rst = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_res = 2'b00;
    logic [1:0] cfg_gain = 2'b00;
    logic       cfg_oneshot = 1'b0;
    logic       start_req = 1'b0;
    logic       auto_done = 1'b0;
    logic       man_done = 1'b0;
    logic       mod_done;
    logic       result_rd = 1'b0;
    logic       mod_en;
    logic [1:0] res_code;
    logic [1:0] gain_code;
    logic       result_rdy;
    logic       standby;

    int total = 0;
    int bad = 0;

    assign mod_done = auto_done | man_done;

    always #5 clk = ~clk;

    adc_conv_seq #(
        .SETTLE_CYC (SETTLE),
        .PRESC_DIV  (PRE),
        .BASE_TICKS (BASE)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gcall_rst   (gcall_rst),
        .cfg_we      (cfg_we),
        .cfg_res     (cfg_res),
        .cfg_gain    (cfg_gain),
        .cfg_oneshot (cfg_oneshot),
        .start_req   (start_req),
        .mod_done    (mod_done),
        .result_rd   (result_rd),
        .mod_en      (mod_en),
        .res_code    (res_code),
        .gain_code   (gain_code),
        .result_rdy  (result_rdy),
        .standby     (standby)
    );

    // Modulator model: done pulse three cycles after each enable rise.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (mod_en && !prev) begin
                repeat (3) @(negedge clk);
                auto_done = 1'b1;
                @(negedge clk);
                auto_done = 1'b0;
                prev = mod_en;
            end else begin
                prev = mod_en;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        n = 0;
        prev = mod_en;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            n++;
            if (mod_en && !prev) break;
            prev = mod_en;
        end
    endtask

    task automatic write_cfg(input logic [1:0] r, input logic [1:0] g, input logic os);
        cfg_res = r; cfg_gain = g; cfg_oneshot = os; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_read();
        result_rd = 1'b1;
        tick(1);
        result_rd = 1'b0;
    endtask

    task automatic t_reset();
        tick(3);
        check(res_code == 2'b00, "R1 res", res_code, 0);
        check(gain_code == 2'b00, "R1 gain", gain_code, 0);
        check(!mod_en && !standby && !result_rdy, "R1 flags",
              {mod_en, standby, result_rdy}, 0);
        rst_n = 1'b1;
        tick(SETTLE - 1);
        check(!mod_en, "R5 early", mod_en, 0);
        tick(1);
        check(mod_en, "R5 first start", mod_en, 1);
    endtask

    task automatic t_continuous();
        int n;
        wait_rise(n);
        check(n == P0, "R3 R2 period code 00", n, P0);
        check(!standby, "R3 no standby", standby, 0);
    endtask

    task automatic t_ready();
        int n;
        wait_rise(n);
        tick(6);
        check(result_rdy, "R8 set", result_rdy, 1);
        pulse_read();
        check(!result_rdy, "R8 cleared", result_rdy, 0);
    endtask

    task automatic t_cfg_defer();
        int n;
        wait_rise(n);
        write_cfg(2'b01, 2'b10, 1'b0);
        check(res_code == 2'b00, "R7 res held", res_code, 0);
        check(gain_code == 2'b00, "R7 gain held", gain_code, 0);
        wait_rise(n);
        check(res_code == 2'b01, "R7 res applied", res_code, 1);
        check(gain_code == 2'b10, "R10 gain x4 applied", gain_code, 2);
        wait_rise(n);
        check(n == P0 * 4, "R2 period code 01", n, P0 * 4);
    endtask

    task automatic t_res_high();
        int n;
        write_cfg(2'b10, 2'b11, 1'b0);
        wait_rise(n);
        wait_rise(n);
        check(n == P0 * 16, "R2 period code 10", n, P0 * 16);
        write_cfg(2'b11, 2'b01, 1'b0);
        wait_rise(n);
        check(gain_code == 2'b01, "R10 gain x2", gain_code, 1);
        wait_rise(n);
        check(n == P0 * 64, "R2 period code 11", n, P0 * 64);
    endtask

    task automatic t_start_ignored();
        int n;
        write_cfg(2'b00, 2'b00, 1'b0);
        wait_rise(n);
        fork
            wait_rise(n);
            begin
                tick(5);
                start_req = 1'b1;
                tick(1);
                start_req = 1'b0;
            end
        join
        check(n == P0, "R9 start ignored", n, P0);
    endtask

    task automatic t_oneshot();
        int n;
        int seen;
        write_cfg(2'b00, 2'b00, 1'b1);
        wait_rise(n);
        tick(P0 + 2);
        check(standby && !mod_en, "R4 standby entered", {standby, mod_en}, 2);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (mod_en || !standby) seen++;
        end
        check(seen == 0, "R4 stays idle", seen, 0);
        pulse_read();
        man_done = 1'b1;
        tick(1);
        man_done = 1'b0;
        tick(2);
        check(!result_rdy, "R9 stray done", result_rdy, 0);
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
        tick(SETTLE - 1);
        check(!mod_en && !standby, "R5 wake settle", {mod_en, standby}, 0);
        tick(1);
        check(mod_en, "R5 wake start", mod_en, 1);
        tick(P0 + 2);
        check(standby, "R4 back to standby", standby, 1);
    endtask

    task automatic t_gcall();
        int n;
        write_cfg(2'b01, 2'b11, 1'b0);
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
        tick(SETTLE);
        check(res_code == 2'b01 && gain_code == 2'b11, "R7 from standby",
              {res_code, gain_code}, 7);
        tick(6);
        check(result_rdy, "R8 set again", result_rdy, 1);
        gcall_rst = 1'b1;
        tick(1);
        gcall_rst = 1'b0;
        check(res_code == 2'b00 && gain_code == 2'b00, "R6 codes",
              {res_code, gain_code}, 0);
        check(!result_rdy && !mod_en && !standby, "R6 flags",
              {result_rdy, mod_en, standby}, 0);
        tick(SETTLE - 1);
        check(!mod_en, "R6 settle", mod_en, 0);
        tick(1);
        check(mod_en, "R6 restart", mod_en, 1);
        wait_rise(n);
        check(n == P0 && !standby, "R6 continuous default", n, P0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_continuous();
        t_ready();
        t_cfg_defer();
        t_res_high();
        t_start_ignored();
        t_oneshot();
        t_gcall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule